// File: doc/BRIEF.md
# Multichannel TDM Serial Sample Shifter

This block models the output side of a read-only serial port on a multichannel converter. A free-running counter clocked by the master clock marks the end of each conversion period. At that point the block loads the whole set of channel words into one long shift register and pulls the active-low ready line low. The host then clocks the data out with its own serial clock. That clock is synchronized into the master clock domain, and each detected falling edge advances the data line by one bit. Channel 0 goes first, and each word is sent most significant bit first. After the last local bit, the data line carries the bits captured on the chain input, so several devices can be read as one long frame.

A 3-bit mode input chooses the output format. Only the two time-multiplexed serial codes are active, and they behave the same way. Every other code parks both outputs in an idle state. The conversion period is a run-time input counted in master clock cycles.

Top module: `tdm_adc_shifter`

## Requirements
- R1: With no serial clock activity, `drdy_n` falls once every `period` master clock cycles (`period` >= 3). Between two falls it stays low for `period`-1 cycles.
- R2: The first detected falling edge of `sclk` after `drdy_n` goes low returns `drdy_n` high.
- R3: If data goes unread, `drdy_n` is high for exactly one cycle just before the next load, then falls again.
- R4: A load replaces every unsent bit. When a load and a detected `sclk` fall land in the same cycle, the load wins: `drdy_n` goes low and `dout` shows the new first bit.
- R5: When `drdy_n` falls, `dout` already carries `samples[NCH*WORD_W-1]`, the MSB of channel 0. Channel 0 occupies the top word of the `samples` bus.
- R6: Each detected `sclk` fall moves `dout` to the next bit. The bits come out in bus order from high to low: channel 0 MSB first, down to the LSB of the last channel.
- R7: `din` is captured on each detected `sclk` fall. After all NCH*WORD_W local bits have been sent, the captured bits appear on `dout` in the order they were captured.
- R8: `fmt` values 3'b000 and 3'b001 both select the serial time-multiplexed mode. With any other value, `drdy_n` is held at 1 and `dout` at 0, and `sclk` falls do not move the loaded data.
- R9: While `rst_n` is low, `drdy_n` is 1 and `dout` is 0.
- R10: An `sclk` fall takes effect on the third rising edge of `clk` after it, and not on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Host serial clock; asynchronous to `clk` and no faster than it |
| din | input | 1 | Chain input, captured on `sclk` falls |
| fmt | input | 3 | Output format select |
| period | input | PER_W | Conversion period length in `clk` cycles |
| samples | input | NCH*WORD_W | Channel words, channel 0 in the top bits |
| drdy_n | output | 1 | Active-low data-ready |
| dout | output | 1 | Serial data output |

## Verification
The two functions that can meet in one cycle are the periodic load and a detected serial clock fall. The bench finds a ready edge, then times the drop of `sclk` so that it is detected exactly on the rising edge that ends the next period. It then checks two things. One cycle earlier, the ready line shows the one-cycle high pulse. At the load edge, it reads low and carries the new channel-0 MSB rather than a shifted bit. A later fall then has to produce the second bit of the new data.

// File: rtl/tdm_adc_shifter.sv
module tdm_adc_shifter #(
  parameter int NCH    = 4,
  parameter int WORD_W = 24,
  parameter int PER_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sclk,
  input  logic                    din,
  input  logic [2:0]              fmt,
  input  logic [PER_W-1:0]        period,
  input  logic [NCH*WORD_W-1:0]   samples,
  output logic                    drdy_n,
  output logic                    dout
);
  localparam int TOT = NCH * WORD_W;
  localparam logic [PER_W-1:0] ONE = PER_W'(1);
  localparam logic [PER_W-1:0] TWO = PER_W'(2);

  logic [2:0]       sync_q;
  logic [PER_W-1:0] cnt_q;
  logic [TOT-1:0]   sh_q;
  logic             rdy_q;

  wire spi_on = (fmt == 3'b000) || (fmt == 3'b001);
  wire fall   = sync_q[2] & ~sync_q[1];
  wire step   = fall & spi_on;
  wire tick   = cnt_q >= (period - ONE);
  wire pre    = cnt_q == (period - TWO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      cnt_q  <= '0;
      sh_q   <= '0;
      rdy_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[1:0], sclk};
      cnt_q  <= tick ? '0 : cnt_q + ONE;
      if (tick)      sh_q <= samples;
      else if (step) sh_q <= {sh_q[TOT-2:0], din};
      if (tick)             rdy_q <= 1'b0;
      else if (pre || step) rdy_q <= 1'b1;
    end
  end

  assign drdy_n = spi_on ? rdy_q : 1'b1;
  assign dout   = spi_on & sh_q[TOT-1];

  // R5
  load_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_q) |-> sh_q[TOT-1] == $past(samples[TOT-1]));

  // R2
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !tick) |=> rdy_q);

  // R6
  shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !tick) |=> sh_q[TOT-1] == $past(sh_q[TOT-2]));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_on && !tick) |=> $stable(sh_q));

  // R4
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && step) |=> !rdy_q && sh_q == $past(samples));
endmodule

// File: tb/tdm_adc_shifter_tb.sv
module tdm_adc_shifter_tb_top;
  localparam int NCH = 4, W = 24, PW = 16, TOT = NCH * W;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b1, din = 1'b0;
  logic [2:0] fmt = 3'b000;
  logic [PW-1:0] period = 16'd1000;
  logic [TOT-1:0] samples = '0;
  wire drdy_n, dout;
  int vecs = 0, errs = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tdm_adc_shifter #(.NCH(NCH), .WORD_W(W), .PER_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .din(din), .fmt(fmt),
    .period(period), .samples(samples), .drdy_n(drdy_n), .dout(dout));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_bit(input logic [TOT-1:0] s, input logic [63:0] d, input int k);
    return (k < TOT) ? s[TOT-1-k] : d[k-TOT];
  endfunction

  function automatic logic [TOT-1:0] rnd_samples();
    logic [TOT-1:0] r;
    for (int i = 0; i < TOT; i += 32) r[i +: 32] = $urandom;
    return r;
  endfunction

  task automatic fall_edge(input logic d);
    din = d; sclk = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rise_edge();
    sclk = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_fall();
    logic prev;
    do begin
      prev = drdy_n;
      @(negedge clk);
    end while (!(prev && !drdy_n));
  endtask

  task automatic read_frame(input int nd);
    logic [TOT-1:0] s = samples;
    logic [63:0] d = {$urandom, $urandom};
    chk(dout == s[TOT-1], "R5", dout, s[TOT-1]);
    for (int k = 1; k <= TOT + nd; k++) begin
      fall_edge(d[k-1]);
      chk(dout == exp_bit(s, d, k), (k <= TOT) ? "R6" : "R7", dout, exp_bit(s, d, k));
      if (k == 1) chk(drdy_n == 1'b1, "R2", drdy_n, 1);
      rise_edge();
    end
  endtask

  initial begin
    logic [TOT-1:0] s;
    int n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(drdy_n == 1'b1 && dout == 1'b0, "R9", {drdy_n, dout}, 2'b10);
    samples = rnd_samples();
    rst_n = 1'b1;
    @(negedge clk);
    chk(drdy_n == 1'b1 && dout == 1'b0, "R9", {drdy_n, dout}, 2'b10);

    // R10: synchronizer latency
    wait_fall();
    sclk = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(drdy_n == 1'b0, "R10 early", drdy_n, 0);
    @(posedge clk); @(negedge clk);
    chk(drdy_n == 1'b1, "R10 third edge", drdy_n, 1);
    rise_edge();

    // random frames in both serial codes
    for (int f = 0; f < 3; f++) begin
      samples = rnd_samples();
      fmt = (f == 1) ? 3'b001 : 3'b000;
      wait_fall();
      read_frame(8);
    end
    fmt = 3'b000;

    // R1 / R3 unread timing
    period = 16'd20;
    wait_fall(); wait_fall();
    n = 0;
    while (drdy_n == 1'b0) begin n++; @(negedge clk); end
    chk(n == 19, "R1 low span", n, 19);
    chk(drdy_n == 1'b1, "R3 pulse", drdy_n, 1);
    @(negedge clk);
    chk(drdy_n == 1'b0, "R3 refall", drdy_n, 0);

    // R4 overwrite of a partly read frame
    period = 16'd1000;
    wait_fall();
    for (int k = 0; k < 5; k++) begin fall_edge(1'b0); rise_edge(); end
    s = rnd_samples(); samples = s;
    wait_fall();
    chk(dout == s[TOT-1], "R4 overwrite", dout, s[TOT-1]);
    fall_edge(1'b0);
    chk(dout == s[TOT-2], "R4 overwrite next", dout, s[TOT-2]);
    rise_edge();

    // R4 collision of load and sclk fall
    wait_fall();
    s = rnd_samples(); samples = s;
    repeat (int'(period) - 3) @(posedge clk);
    @(negedge clk);
    sclk = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(drdy_n == 1'b1, "R3 pre-pulse", drdy_n, 1);
    @(posedge clk); @(negedge clk);
    chk(drdy_n == 1'b0 && dout == s[TOT-1], "R4 collision", {drdy_n, dout}, {1'b0, s[TOT-1]});
    rise_edge();
    fall_edge(1'b0);
    chk(dout == s[TOT-2], "R4 after collision", dout, s[TOT-2]);
    rise_edge();

    // R8 idle formats
    for (int m = 2; m < 8; m++) begin
      fmt = 3'(m);
      for (int c = 0; c < 3; c++) begin
        fall_edge(1'b1);
        chk(drdy_n == 1'b1 && dout == 1'b0, "R8 idle", {drdy_n, dout}, 2'b10);
        rise_edge();
      end
    end
    fmt = 3'b000;
    s = rnd_samples(); samples = s;
    wait_fall();
    fmt = 3'b010;
    for (int c = 0; c < 3; c++) begin fall_edge(1'b1); rise_edge(); end
    fmt = 3'b000;
    @(negedge clk);
    chk(dout == s[TOT-1], "R8 no shift while idle", dout, s[TOT-1]);

    samples = rnd_samples();
    wait_fall();
    read_frame(4);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      vecs++; errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule